// File: doc/BRIEF.md
# Folded Symmetric FIR Filter Cell

This block is one filter cell of a finite impulse response filter that takes advantage of symmetric coefficient sets. Each incoming 10-bit sample passes through a forward chain of registers and then on into a reverse chain that runs the opposite way. Each tap pair has one coefficient. For each pair, a pre-adder merges the forward sample with its mirror image in the reverse chain before the single multiply. Eight symmetric (or antisymmetric) taps therefore need only four multipliers. With an arbitrary coefficient set, the cell falls back to four direct taps on the forward chain.

Each sample and each coefficient has its own selection between unsigned and two's-complement format, so mixed formats work. A freeze input stops sample intake while the coefficients and controls still take effect. The 28-bit result is exact. An optional rounding constant can be added at one of twelve binary weights. All inputs are registered on the same clock edge, and the result they produce leaves the cell on a registered output a fixed number of cycles later.

Top module: `sfir_cell`

## Requirements
- R1: `data_tc` = 0 treats samples as unsigned and `data_tc` = 1 treats them as two's complement. `coef_tc` selects the same way for the coefficients. All four combinations give exact products.
- R2: With `fold_mode` = 2'b00 (symmetric), the result is sum over k=0..3 of c_k·(x[n−k] + x[n−7+k]). Here x[n] is the newest captured sample and c_k is `coef[10k+9:10k]`.
- R3: With `fold_mode` = 2'b01 (antisymmetric), the result is sum over k=0..3 of c_k·(x[n−k] − x[n−7+k]). The pre-adder never overflows, for any operand values or formats.
- R4: With `fold_mode` = 2'b10 or 2'b11 (direct), the result is sum over k=0..3 of c_k·x[n−k], and the reverse chain has no effect.
- R5: While `freeze` = 1, `din` is ignored and both chains hold their samples. While `freeze` = 0, one sample enters per clock, and each chain shifts by one place.
- R6: All inputs are sampled on the same rising edge. The result computed from them appears on `dout` right after the fourth rising edge that follows.
- R7: `dout` is the full-precision sum as a 28-bit two's-complement value, sign-extended when negative.
- R8: With `rnd_dis` = 0 and `rnd_pos` = c ≤ 11, 2^c is added to the 28-bit sum, where bit c of the sum has weight 2^(c−10). Codes 12 to 15, or `rnd_dis` = 1, add nothing.
- R9: A synchronous active-high `rst` clears both chains and drives `dout` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 10 | Input sample |
| coef | input | 40 | Four coefficients; c_k in bits 10k+9..10k |
| data_tc | input | 1 | Sample format: 0 unsigned, 1 two's complement |
| coef_tc | input | 1 | Coefficient format: 0 unsigned, 1 two's complement |
| fold_mode | input | 2 | 00 symmetric, 01 antisymmetric, 1x direct |
| freeze | input | 1 | 1 holds the sample chains and ignores din |
| rnd_pos | input | 4 | Rounding weight code |
| rnd_dis | input | 1 | 0 enables rounding, 1 disables it |
| dout | output | 28 | Filter result |

## Verification
Random samples with fresh coefficients on every clock are run through each folding mode and each of the four format combinations. This separates the add, subtract and pass paths of the pre-adder and exposes any wrong extension of an operand. Samples limited to the range endpoints drive the pre-adder and the sign extension to their limits. A lone impulse among zeros shows whether the taps pair the correct forward and reverse positions with the correct coefficient, and whether the result comes out in the correct cycle. Random freeze patterns and a sweep through all sixteen round codes, with rounding both on and off, check intake hold and the constant that is added.

// File: rtl/sfir_pkg.sv
package sfir_pkg;
  typedef enum logic [1:0] {
    FOLD_SYM  = 2'b00,
    FOLD_ANTI = 2'b01,
    FOLD_PASS = 2'b10,
    FOLD_PAS2 = 2'b11
  } fold_e;
endpackage

// File: rtl/sfir_delay_line.sv
module sfir_delay_line #(
  parameter int DW    = 10,
  parameter int NPAIR = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        freeze,
  input  logic [DW-1:0]               din,
  output logic [NPAIR-1:0][DW-1:0]    fwd,
  output logic [NPAIR-1:0][DW-1:0]    rev
);
  // forward chain moves toward higher index, reverse chain toward lower
  always_ff @(posedge clk) begin
    if (rst) begin
      fwd <= '0;
      rev <= '0;
    end else if (!freeze) begin
      fwd[0]       <= din;
      rev[NPAIR-1] <= fwd[NPAIR-1];
      for (int k = 1; k < NPAIR; k++) fwd[k] <= fwd[k-1];
      for (int j = 0; j < NPAIR-1; j++) rev[j] <= rev[j+1];
    end
  end

  AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    freeze |=> ($stable(fwd) && $stable(rev)));                     // R5
  AST_FWD_SHIFT: assert property (@(posedge clk) disable iff (rst)
    !freeze |=> (fwd[1] == $past(fwd[0])));                         // R5
  AST_REV_SHIFT: assert property (@(posedge clk) disable iff (rst)
    !freeze |=> (rev[0] == $past(rev[1])));                         // R5
endmodule

// File: rtl/sfir_tap.sv
module sfir_tap
  import sfir_pkg::*;
#(
  parameter int DW  = 10,
  parameter int CW  = 10,
  parameter int PW  = DW + 2,
  parameter int CXW = CW + 1,
  parameter int MW  = PW + CXW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [CW-1:0] c,
  input  logic          data_tc,
  input  logic          coef_tc,
  input  fold_e         mode,
  output logic [MW-1:0] prod
);
  localparam int PRE_MIN = -(1 << DW);
  localparam int PRE_MAX = (1 << (DW + 1)) - 2;

  logic signed [PW-1:0]  ea, eb, pre_d, pre_q;
  logic signed [CXW-1:0] cx_d, cx_q;
  logic signed [MW-1:0]  prod_q;

  always_comb begin
    ea   = {{(PW-DW){data_tc & a[DW-1]}}, a};
    eb   = {{(PW-DW){data_tc & b[DW-1]}}, b};
    cx_d = {coef_tc & c[CW-1], c};
    case (mode)
      FOLD_SYM:  pre_d = ea + eb;
      FOLD_ANTI: pre_d = ea - eb;
      default:   pre_d = ea;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      cx_q   <= '0;
      prod_q <= '0;
    end else begin
      pre_q  <= pre_d;
      cx_q   <= cx_d;
      prod_q <= pre_q * cx_q;
    end
  end

  assign prod = prod_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    ($signed(pre_q) >= PRE_MIN) && ($signed(pre_q) <= PRE_MAX));   // R3
endmodule

// File: rtl/sfir_sum_round.sv
module sfir_sum_round #(
  parameter int MW    = 23,
  parameter int NPAIR = 4,
  parameter int OW    = 28,
  parameter int RCW   = 4,
  parameter int RMAX  = 11
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NPAIR-1:0][MW-1:0] prods,
  input  logic [RCW-1:0]           rnd_pos,
  input  logic                     rnd_dis,
  output logic [OW-1:0]            dout
);
  localparam int SW = MW + $clog2(NPAIR) + 1;

  logic signed [SW-1:0] acc, sum_q;
  logic [RCW-1:0]       rpos_q;
  logic                 rdis_q;
  logic [OW-1:0]        sum_ext, rnd_add;

  always_comb begin
    acc = '0;
    for (int k = 0; k < NPAIR; k++)
      acc = acc + {{(SW-MW){prods[k][MW-1]}}, prods[k]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q  <= '0;
      rpos_q <= '0;
      rdis_q <= 1'b1;
    end else begin
      sum_q  <= acc;
      rpos_q <= rnd_pos;
      rdis_q <= rnd_dis;
    end
  end

  always_comb begin
    sum_ext = {{(OW-SW){sum_q[SW-1]}}, sum_q};
    rnd_add = (!rdis_q && (rpos_q <= RCW'(RMAX))) ? (OW'(1) << rpos_q) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else     dout <= sum_ext + rnd_add;
  end

  AST_RND_BOUND: assert property (@(posedge clk) disable iff (rst)
    ((dout - $past(sum_ext)) <= OW'(1 << RMAX)));                   // R8
endmodule

// File: rtl/sfir_cell.sv
module sfir_cell
  import sfir_pkg::*;
#(
  parameter int DW    = 10,
  parameter int CW    = 10,
  parameter int NPAIR = 4,
  parameter int OW    = 28,
  parameter int RCW   = 4,
  parameter int RMAX  = 11
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [DW-1:0]         din,
  input  logic [NPAIR*CW-1:0]   coef,
  input  logic                  data_tc,
  input  logic                  coef_tc,
  input  logic [1:0]            fold_mode,
  input  logic                  freeze,
  input  logic [RCW-1:0]        rnd_pos,
  input  logic                  rnd_dis,
  output logic [OW-1:0]         dout
);
  localparam int PW  = DW + 2;
  localparam int CXW = CW + 1;
  localparam int MW  = PW + CXW;

  logic [NPAIR-1:0][DW-1:0] fwd, rev;
  logic [NPAIR-1:0][MW-1:0] prods;
  logic [NPAIR*CW-1:0]      coef_q;
  logic                     dtc_q, ctc_q;
  logic [1:0]               mode_q;
  logic [RCW-1:0]           rpos_q0, rpos_q1, rpos_q2;
  logic                     rdis_q0, rdis_q1, rdis_q2;

  sfir_delay_line #(.DW(DW), .NPAIR(NPAIR)) u_chain (
    .clk(clk), .rst(rst), .freeze(freeze), .din(din), .fwd(fwd), .rev(rev)
  );

  // controls and coefficients ride along with the sample of the same edge
  always_ff @(posedge clk) begin
    if (rst) begin
      coef_q  <= '0;
      dtc_q   <= 1'b0;
      ctc_q   <= 1'b0;
      mode_q  <= 2'b00;
      rpos_q0 <= '0;  rpos_q1 <= '0;  rpos_q2 <= '0;
      rdis_q0 <= 1'b1; rdis_q1 <= 1'b1; rdis_q2 <= 1'b1;
    end else begin
      coef_q  <= coef;
      dtc_q   <= data_tc;
      ctc_q   <= coef_tc;
      mode_q  <= fold_mode;
      rpos_q0 <= rnd_pos;  rpos_q1 <= rpos_q0; rpos_q2 <= rpos_q1;
      rdis_q0 <= rnd_dis;  rdis_q1 <= rdis_q0; rdis_q2 <= rdis_q1;
    end
  end

  for (genvar k = 0; k < NPAIR; k++) begin : g_tap
    sfir_tap #(.DW(DW), .CW(CW), .PW(PW), .CXW(CXW), .MW(MW)) u_tap (
      .clk(clk), .rst(rst),
      .a(fwd[k]), .b(rev[k]), .c(coef_q[k*CW +: CW]),
      .data_tc(dtc_q), .coef_tc(ctc_q), .mode(fold_e'(mode_q)),
      .prod(prods[k])
    );
  end

  sfir_sum_round #(.MW(MW), .NPAIR(NPAIR), .OW(OW), .RCW(RCW), .RMAX(RMAX)) u_out (
    .clk(clk), .rst(rst), .prods(prods),
    .rnd_pos(rpos_q2), .rnd_dis(rdis_q2), .dout(dout)
  );
endmodule

// File: tb/sfir_cell_test.sv
module sfir_cell_test;
  typedef struct {
    logic [27:0] val;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  din = '0;
  logic [39:0] coef = '0;
  logic        data_tc = 1'b0, coef_tc = 1'b0, freeze = 1'b0, rnd_dis = 1'b1;
  logic [1:0]  fold_mode = 2'b00;
  logic [3:0]  rnd_pos = '0;
  logic [27:0] dout;

  int n_cmp = 0, n_bad = 0;
  int hist [8];
  exp_t sb [$];

  always #2 clk = ~clk;

  sfir_cell uut (
    .clk(clk), .rst(rst), .din(din), .coef(coef), .data_tc(data_tc),
    .coef_tc(coef_tc), .fold_mode(fold_mode), .freeze(freeze),
    .rnd_pos(rnd_pos), .rnd_dis(rnd_dis), .dout(dout)
  );

  function automatic longint sx(int v, bit tc);
    if (tc && v[9]) return longint'(v) - 1024;
    return longint'(v);
  endfunction

  task automatic step(input int x, input int c [4], input bit dtc, input bit ctc,
                      input int md, input bit frz, input int rp, input bit rd,
                      input string tag);
    longint acc, a, b, p;
    exp_t e;
    @(negedge clk);
    din = 10'(x); data_tc = dtc; coef_tc = ctc; fold_mode = 2'(md);
    freeze = frz; rnd_pos = 4'(rp); rnd_dis = rd;
    for (int k = 0; k < 4; k++) coef[k*10 +: 10] = 10'(c[k]);
    if (!frz) begin
      for (int i = 7; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = x & 1023;
    end
    acc = 0;
    for (int k = 0; k < 4; k++) begin
      a = sx(hist[k], dtc);
      b = sx(hist[7-k], dtc);
      p = (md == 0) ? a + b : (md == 1) ? a - b : a;
      acc += p * sx(c[k] & 1023, ctc);
    end
    if (!rd && rp <= 11) acc += longint'(1) << rp;
    e.val = acc[27:0];
    e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: the item driven before edge t is due just after edge t+4
  always @(posedge clk) begin
    #1;
    if (sb.size() >= 5) begin
      exp_t e;
      e = sb.pop_front();
      n_cmp++;
      if (dout !== e.val) begin
        n_bad++;
        $display("FAIL %s: dout=%h expected=%h", e.tag, dout, e.val);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  function automatic int rnd10();
    return int'($urandom_range(0, 1023));
  endfunction

  initial begin
    int c [4];
    int ext [4];
    for (int i = 0; i < 8; i++) hist[i] = 0;
    repeat (4) @(negedge clk);
    n_cmp++;
    if (dout !== 28'h0) begin
      n_bad++;
      $display("FAIL R9: dout=%h expected=%h", dout, 28'h0);
    end
    rst = 1'b0;

    // R2: symmetric, unsigned operands, coefficients changing every clock
    for (int i = 0; i < 30; i++) begin
      for (int k = 0; k < 4; k++) c[k] = rnd10();
      step(rnd10(), c, 0, 0, 0, 0, 0, 1, "R2");
    end
    // R1: every combination of operand formats
    for (int f = 0; f < 4; f++)
      for (int i = 0; i < 20; i++) begin
        for (int k = 0; k < 4; k++) c[k] = rnd10();
        step(rnd10(), c, f[0], f[1], 0, 0, 0, 1, "R1");
      end
    // R3: antisymmetric with range endpoints
    ext = '{0, 1023, 512, 511};
    for (int i = 0; i < 40; i++) begin
      for (int k = 0; k < 4; k++) c[k] = ext[$urandom_range(0, 3)];
      step(ext[$urandom_range(0, 3)], c, i[0], i[1], 1, 0, 0, 1, "R3");
    end
    // R4: direct taps, both encodings
    for (int i = 0; i < 40; i++) begin
      for (int k = 0; k < 4; k++) c[k] = rnd10();
      step(rnd10(), c, i[2], i[3], (i < 20) ? 2 : 3, 0, 0, 1, "R4");
    end
    // R7: largest magnitude results, negative and positive
    for (int i = 0; i < 24; i++) begin
      for (int k = 0; k < 4; k++) c[k] = (i < 12) ? 511 : 512;
      step(512, c, 1, 1, 0, 0, 0, 1, "R7");
    end
    for (int i = 0; i < 12; i++) begin
      for (int k = 0; k < 4; k++) c[k] = 1023;
      step(1023, c, 0, 0, 0, 0, 0, 1, "R7");
    end
    // R5: freeze toggled at random
    for (int i = 0; i < 60; i++) begin
      for (int k = 0; k < 4; k++) c[k] = rnd10();
      step(rnd10(), c, 1, 1, i % 3, $urandom_range(0, 1), 0, 1, "R5");
    end
    // R6: lone impulse locates every tap pairing and the output cycle
    c = '{1, 2, 4, 8};
    for (int i = 0; i < 8; i++) step(0, c, 0, 0, 0, 0, 0, 1, "R6");
    step(1, c, 0, 0, 0, 0, 0, 1, "R6");
    for (int i = 0; i < 10; i++) step(0, c, 0, 0, 0, 0, 0, 1, "R6");
    step(1, c, 0, 0, 1, 0, 0, 1, "R6");
    for (int i = 0; i < 10; i++) step(0, c, 0, 0, 1, 0, 0, 1, "R6");
    // R8: every round code, rounding on and off
    for (int i = 0; i < 64; i++) begin
      for (int k = 0; k < 4; k++) c[k] = rnd10();
      step(rnd10(), c, 1, 0, 0, 0, i % 16, (i >= 32) ? $urandom_range(0, 1) : 0, "R8");
    end
    // drain
    for (int i = 0; i < 6; i++) step(0, c, 0, 0, 0, 0, 0, 1, "R6");
    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule